// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is an SPI master that a processor drives through three word registers on a simple memory-mapped bus. Software first loads up to four outgoing bytes into the transmit register. It then writes a control word, and that write starts a transfer. The control word picks the target chip out of four, the direction (write or read), the number of bytes from one to four, the byte order, the SCK half period, the chip-select setup and hold interval, and whether chip select is released when the transfer ends. Software polls the busy bit at the top of the control register. After a read, the incoming bytes are in the receive register.

Chip select can be left asserted at the end of a transfer. The next launched transfer then continues the same bus transaction. This lets software build one long flash access from separate command, address, dummy and data transfers, and each of those transfers chooses its own byte order. The bus uses SPI mode 0: SCK idles low, the master changes MOSI after a falling edge, and MISO is captured on a rising edge. Bytes are always shifted most significant bit first.

Top module: `spi_reg_master`

## Requirements
- R1: Reset state. While reset is low and after it is released:
  - all chip-select outputs are high, and SCK and MOSI are low;
  - the control, transmit and receive registers all read zero.
- R2: Register reads:
  - a read at byte offset 0x0 returns the busy flag in bit 31, zeros in bits 30:26, and the last accepted control bits 25:0;
  - offset 0x4 returns the transmit word and offset 0x8 the receive word.
- R3: Launch and busy. A control write with bit 31 set, while idle, starts a transfer, and bit 31 reads 1 for exactly S+(2N-1)P+H cycles, counted from the clock edge after the write. N is 8 times the byte count.
  - Control fields: bit 25 byte order (1 = big), bits 24:23 chip number, bits 22:21 operation (1 = read, any other value = write), bits 20:19 byte count minus one, bits 18:13 half period, bits 12:8 setup/hold, bits 7:0 chip-select control.
  - P, S and H are the half-period and setup/hold fields, each with 0 treated as 1 (S and H both come from the setup/hold field).
- R4: SCK follows mode 0. It is low while idle, each high phase and each low phase lasts P cycles, and it gives exactly N rising edges per transfer.
- R5: Chip-select timing. The first SCK rising edge comes S cycles after chip select goes low. When chip select is released, it rises H cycles after the last SCK falling edge.
- R6: Transmit byte order. Bytes are taken left-justified.
  - Big order sends byte lanes 3, 2, 1, 0.
  - Little order sends lanes 4-n up to 3 in ascending order, where n is the byte count.
  - So a one-byte write always sends bits 31:24. Each byte goes out MSB first.
  - MOSI changes only at launch or together with a falling SCK edge.
- R7: Receive placement.
  - MISO is captured on each rising SCK edge.
  - Received byte j (0 = first) lands in lane 3-j for big order, or lane 4-n+j for little order.
  - Unused lanes read zero.
  - A write-operation transfer leaves the receive register unchanged.
- R8: During a read-operation transfer, MOSI stays low.
- R9: Chip-select decode. The chip field selects exactly one active-low output, and at most one chip-select output is ever low.
- R10: Chip-select release. If bit 0 of the chip-select control field is 1, chip select is released when busy clears. If it is 0, chip select stays low without a gap into the next launched transfer.
- R11: A write to offset 0x0 while busy is ignored. It neither changes the stored control fields nor launches anything. A control write with bit 31 clear, while idle, stores the fields without starting a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
A wrong sequencer state or counter first appears as an SCK, MOSI or chip-select level that differs from the reference model. It shows up in the very cycle the state goes wrong, because every one of those outputs is compared on every clock. A wrong byte-lane choice in the transmit path shows as a MOSI bit error on the first affected bit. A receive-side mistake stays hidden until software reads offset 0x8 after busy clears, so every read transfer in the bench ends with that readback. A dropped or extra launch shows at once as a busy or SCK mismatch.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int NUM_CS  = 4;
  localparam int CS_W    = $clog2(NUM_CS);
  localparam int PER_W   = 6;
  localparam int SH_W    = 5;
  localparam int CNT_W   = (PER_W > SH_W) ? PER_W : SH_W;
  localparam int BITS_W  = $clog2(WORD_W);
  localparam int CFG_W   = 26;
  localparam int OFF_CTRL = 'h0;
  localparam int OFF_TX   = 'h4;
  localparam int OFF_RX   = 'h8;
  localparam logic [1:0] OP_READ = 2'd1;

  // Packed in control-word bit order: endianBig is bit 25, csCtl is bits 7:0.
  typedef struct packed {
    logic              endianBig;
    logic [CS_W-1:0]   chip;
    logic [1:0]        op;
    logic [1:0]        cntM1;
    logic [PER_W-1:0]  period;
    logic [SH_W-1:0]   setupHold;
    logic [7:0]        csCtl;
  } cfg_t;

  typedef struct packed {
    logic load;      // launch accepted: prime shifters
    logic sample;    // SCK rising: capture MISO
    logic shiftOut;  // SCK falling: present next MOSI bit
    logic finish;    // end of hold: commit receive word
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD
  } state_t;
endpackage

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic              miso,
  output logic              mosi,
  input  logic              busy,
  input  strobe_t           strobe,
  output logic              launch,
  output cfg_t              cfgView,
  output cfg_t              cfgStored
);
  localparam int LANES = WORD_W / BYTE_W;

  cfg_t              cfgReg;
  logic [WORD_W-1:0] txReg, rxReg, txShift, rxShift;
  logic              ctrlWr, txWr, accept;
  logic [WORD_W-1:0] txOrdered, rxAligned, rxPlaced;
  logic [BITS_W-1:0] padBits;

  function automatic logic [WORD_W-1:0] byteRev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*BYTE_W +: BYTE_W] = w[(LANES-1-i)*BYTE_W +: BYTE_W];
    return r;
  endfunction

  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(OFF_CTRL));
  assign txWr   = busWrEn && (busAddr == ADDR_W'(OFF_TX));
  assign accept = ctrlWr && !busy;
  assign launch = accept && busWrData[WORD_W-1];

  assign cfgView   = launch ? cfg_t'(busWrData[CFG_W-1:0]) : cfgReg;
  assign cfgStored = cfgReg;

  // Unused lanes sit at the bottom: shift by (lanes - count) bytes.
  always_comb begin
    padBits   = BITS_W'({3'd0, ~cfgView.cntM1} << 3);
    txOrdered = cfgView.endianBig ? txReg : (byteRev(txReg) << padBits);
    rxAligned = rxShift << padBits;
    rxPlaced  = cfgView.endianBig ? rxAligned : (byteRev(rxAligned) << padBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      txReg   <= '0;
      rxReg   <= '0;
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
    end else begin
      if (accept) cfgReg <= cfg_t'(busWrData[CFG_W-1:0]);
      if (txWr)   txReg  <= busWrData;
      if (strobe.load) begin
        rxShift <= '0;
        if (cfgView.op == OP_READ) begin
          txShift <= '0;
          mosi    <= 1'b0;
        end else begin
          txShift <= txOrdered << 1;
          mosi    <= txOrdered[WORD_W-1];
        end
      end else begin
        if (strobe.shiftOut) begin
          mosi    <= txShift[WORD_W-1];
          txShift <= txShift << 1;
        end
        if (strobe.sample) rxShift <= {rxShift[WORD_W-2:0], miso};
      end
      if (strobe.finish && cfgReg.op == OP_READ) rxReg <= rxPlaced;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFF_CTRL): busRdData = {busy, {(WORD_W-1-CFG_W){1'b0}}, cfgReg};
      ADDR_W'(OFF_TX):   busRdData = txReg;
      ADDR_W'(OFF_RX):   busRdData = rxReg;
      default:           busRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              launch,
  input  cfg_t              cfgView,
  output strobe_t           strobe,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN
);
  state_t            state;
  logic [CNT_W-1:0]  phaseCnt, halfLen, shLen;
  logic [BITS_W-1:0] bitCnt;
  logic              csActive, lastPhase;
  logic [CS_W-1:0]   csSel;

  assign halfLen   = (cfgView.period == '0) ? CNT_W'(1) : CNT_W'(cfgView.period);
  assign shLen     = (cfgView.setupHold == '0) ? CNT_W'(1) : CNT_W'(cfgView.setupHold);
  assign lastPhase = (phaseCnt == '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.load     = launch && (state == ST_IDLE);
    strobe.sample   = lastPhase && ((state == ST_SETUP) || (state == ST_LOW));
    strobe.shiftOut = lastPhase && (state == ST_HIGH) && (bitCnt != '0);
    strobe.finish   = lastPhase && (state == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sclk     <= 1'b0;
      csActive <= 1'b0;
      csSel    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state    <= ST_SETUP;
          phaseCnt <= shLen - CNT_W'(1);
          bitCnt   <= {cfgView.cntM1, 3'b111};
          csActive <= 1'b1;
          csSel    <= cfgView.chip;
        end
        ST_SETUP, ST_LOW: if (lastPhase) begin
          state    <= ST_HIGH;
          sclk     <= 1'b1;
          phaseCnt <= halfLen - CNT_W'(1);
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        ST_HIGH: if (lastPhase) begin
          sclk <= 1'b0;
          if (bitCnt == '0) begin
            state    <= ST_HOLD;
            phaseCnt <= shLen - CNT_W'(1);
          end else begin
            state    <= ST_LOW;
            phaseCnt <= halfLen - CNT_W'(1);
            bitCnt   <= bitCnt - BITS_W'(1);
          end
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        ST_HOLD: if (lastPhase) begin
          state <= ST_IDLE;
          if (cfgView.csCtl[0]) csActive <= 1'b0;
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csDecode
    assign csN[i] = !(csActive && (csSel == CS_W'(i)));
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  strobe_t strobe;
  logic    busy, launch;
  cfg_t    cfgView, cfgStored;

  spi_reg_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .miso(miso), .mosi(mosi),
    .busy(busy), .strobe(strobe), .launch(launch), .cfgView(cfgView),
    .cfgStored(cfgStored)
  );

  spi_reg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .launch(launch), .cfgView(cfgView),
    .strobe(strobe), .busy(busy), .sclk(sclk), .csN(csN)
  );
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] csN,
  input logic              busy,
  input cfg_t              cfgStored
);
  a_r9_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  a_r5_cs_under_sclk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !(&csN));

  a_r8_read_mosi_low: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgStored.op == OP_READ) |-> !mosi);

  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWrEn && busAddr == ADDR_W'(OFF_CTRL)) |=> $stable(cfgStored));

  a_r10_release_on_done: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && cfgStored.csCtl[0]) |-> (&csN));
endmodule

bind spi_reg_master spi_reg_master_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .sclk(sclk), .mosi(mosi), .csN(csN), .busy(busy), .cfgStored(cfgStored)
);

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        sclk, mosi, miso;
  logic [3:0]  csN;

  always #5 clk = ~clk;

  spi_reg_master dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  typedef struct packed {
    logic       busy;
    logic       sclk;
    logic [3:0] csN;
    logic       mosi;
  } exp_t;

  int   total = 0, bad = 0, cyc = 0, prints = 0;
  exp_t q[$];
  bit   capBits[$];
  bit   runCmp = 0, curBusy = 0, idleMosi = 0;
  logic [3:0]  idleCs = 4'hF;
  logic [31:0] txModel = '0, rxModel = '0;
  logic [25:0] cfgModel = '0;
  bit   rxPending = 0, rxBig = 0;
  int   rxN = 0;
  int   slaveIdx = 0;

  // Mode-0 slave: next bit after each falling SCK edge.
  always @(negedge sclk) slaveIdx++;
  assign miso = (((slaveIdx * 13) ^ (slaveIdx >> 1)) & 1) != 0;
  always @(posedge sclk) capBits.push_back(miso);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      if (prints < 30) $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      prints++;
    end
  endtask

  // Per-cycle comparison against the behavioural model.
  always @(posedge clk) begin
    exp_t e;
    logic [6:0] act;
    #2;
    if (runCmp) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{busy: 1'b0, sclk: 1'b0, csN: idleCs, mosi: idleMosi};
      curBusy = e.busy;
      act = {(busAddr == 4'h0) ? busRdData[31] : e.busy, sclk, csN, mosi};
      chk("R3 R4 R5 R6 R9 R10 cycle", {25'd0, act}, {25'd0, e});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic buildModel(input logic [31:0] w);
    bit big = w[25];
    int chip = int'(w[24:23]);
    bit rd = (w[22:21] == 2'd1);
    int n = int'(w[20:19]) + 1;
    int p = (w[18:13] == 0) ? 1 : int'(w[18:13]);
    int s = (w[12:8] == 0) ? 1 : int'(w[12:8]);
    int h = s;
    logic [3:0] cs = ~(4'b0001 << chip);
    bit bits[$];
    for (int j = 0; j < n; j++) begin
      int lane = big ? 3 - j : (4 - n) + j;
      for (int b = 7; b >= 0; b--) bits.push_back(rd ? 1'b0 : txModel[lane*8 + b]);
    end
    for (int i = 0; i < s; i++) q.push_back('{1'b1, 1'b0, cs, bits[0]});
    for (int k = 0; k < 8*n; k++) begin
      for (int i = 0; i < p; i++) q.push_back('{1'b1, 1'b1, cs, bits[k]});
      if (k < 8*n - 1)
        for (int i = 0; i < p; i++) q.push_back('{1'b1, 1'b0, cs, bits[k+1]});
      else
        for (int i = 0; i < h; i++) q.push_back('{1'b1, 1'b0, cs, bits[k]});
    end
    idleCs   = w[0] ? 4'hF : cs;
    idleMosi = bits[8*n-1];
    capBits.delete();
    rxPending = rd; rxBig = big; rxN = n;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    if (a == 4'h4) txModel = d;
    if (a == 4'h0 && !curBusy) begin
      cfgModel = d[25:0];
      if (d[31]) buildModel(d);
    end
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 4'h0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; #1; d = busRdData; busAddr = 4'h0;
  endtask

  task automatic waitIdle();
    while (q.size() != 0 || curBusy) @(negedge clk);
    if (rxPending) begin
      logic [31:0] r = '0;
      for (int j = 0; j < rxN; j++) begin
        int lane = rxBig ? 3 - j : (4 - rxN) + j;
        for (int b = 0; b < 8; b++) r[lane*8 + 7 - b] = capBits[j*8 + b];
      end
      rxModel = r;
      rxPending = 0;
    end
  endtask

  function automatic logic [31:0] ctl(input bit big, input int chip, input bit rd,
      input int n, input int per, input int sh, input logic [7:0] csc);
    return {1'b1, 5'd0, big, 2'(chip), rd ? 2'd1 : 2'd0, 2'(n - 1), 6'(per), 5'(sh), csc};
  endfunction

  task automatic checkRx(input string tag);
    logic [31:0] d;
    busRead(4'h8, d); chk(tag, d, rxModel);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: outputs held idle during reset
    chk("R1 reset outputs", {26'd0, sclk, mosi, csN}, {26'd0, 1'b0, 1'b0, 4'hF});
    rstN = 1'b1;
    runCmp = 1;
    busRead(4'h0, d); chk("R1 ctrl after reset", d, 32'h0);
    busRead(4'h4, d); chk("R1 tx after reset", d, 32'h0);
    busRead(4'h8, d); chk("R1 rx after reset", d, 32'h0);

    // R6 big-order 4-byte write, chip 0, release
    busWrite(4'h4, 32'hA1B2C3D4);
    busRead(4'h4, d); chk("R2 tx readback", d, 32'hA1B2C3D4);
    busWrite(4'h0, ctl(1, 0, 0, 4, 2, 2, 8'h01));
    busRead(4'h0, d); chk("R2 R3 busy readback", d, {1'b1, 5'd0, cfgModel});
    waitIdle();
    busRead(4'h0, d); chk("R2 R3 ctrl after done", d, {1'b0, 5'd0, cfgModel});

    // R6 little-order 4-byte write, chip 1
    busWrite(4'h4, 32'h0F1E2D3C);
    busWrite(4'h0, ctl(0, 1, 0, 4, 1, 3, 8'h01)); waitIdle();
    // R6 one-byte little write still sends [31:24]
    busWrite(4'h4, 32'h5A000081);
    busWrite(4'h0, ctl(0, 2, 0, 1, 3, 1, 8'h01)); waitIdle();
    // R7 rx unchanged by write-op transfer
    checkRx("R7 rx kept by write op");

    // R7 R8 one-byte big read, chip 3
    busWrite(4'h0, ctl(1, 3, 1, 1, 2, 2, 8'h01)); waitIdle();
    checkRx("R7 one-byte big read");
    // R4 R5 zero period and setup clamp to one, little 4-byte read
    busWrite(4'h0, ctl(0, 0, 1, 4, 0, 0, 8'h01)); waitIdle();
    checkRx("R7 little 4-byte read");
    busWrite(4'h0, ctl(0, 2, 1, 2, 1, 1, 8'h01)); waitIdle();
    checkRx("R7 little 2-byte read");
    busWrite(4'h0, ctl(1, 1, 1, 3, 2, 4, 8'h01)); waitIdle();
    checkRx("R7 big 3-byte read");

    // R10 chip select held across command and data transfers
    busWrite(4'h4, 32'h03123456);
    busWrite(4'h0, ctl(1, 1, 0, 4, 2, 2, 8'h00)); waitIdle();
    chk("R10 cs held low", {28'd0, csN}, {28'd0, 4'b1101});
    busWrite(4'h0, ctl(1, 1, 0, 1, 2, 2, 8'h00)); waitIdle();
    busWrite(4'h0, ctl(0, 1, 1, 4, 2, 2, 8'h01)); waitIdle();
    checkRx("R10 R7 read after held cs");
    chk("R10 cs released", {28'd0, csN}, {28'd0, 4'hF});

    // R11 control write while busy is ignored
    busWrite(4'h0, ctl(1, 2, 0, 4, 4, 3, 8'h01));
    repeat (20) @(negedge clk);
    busWrite(4'h0, ctl(0, 3, 1, 1, 1, 1, 8'h00));
    waitIdle();
    busRead(4'h0, d); chk("R11 busy write ignored", d, {1'b0, 5'd0, cfgModel});
    chk("R11 fields kept", {6'd0, d[25:0]}, {6'd0, ctl(1, 2, 0, 4, 4, 3, 8'h01) & 32'h03FFFFFF});
    // R11 store without launch
    busWrite(4'h0, ctl(1, 2, 1, 2, 5, 6, 8'h11) & 32'h7FFFFFFF);
    repeat (10) @(negedge clk);
    busRead(4'h0, d); chk("R11 store no launch", d, {6'd0, cfgModel});
    chk("R9 idle cs after store", {28'd0, csN}, {28'd0, 4'hF});

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule